// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a phase-locked loop safely from one multiplier setting to another. A single start pulse carries the new multiplier word and the present value of the PLL's control register. The sequencer then issues a fixed series of register writes to the PLL over a valid/ready write port. First it powers the loop down and removes bypass, the direct paths and the output enable. Next it loads the multiplier word and the fixed pre/post divider word, and then it powers the loop back up. After that it polls the lock flag, waiting a fixed interval before each look, and gives up after a bounded number of looks.

On lock it turns the clock output on with one last control write and raises `done_o`. If lock never comes, it raises `error_o`, and the output enable stays cleared. The wait interval is set in cycles, derived from the system clock frequency and a wait time in nanoseconds. The default wait is 500 cycles at 50 MHz, with up to 4 lock checks.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `wr_valid_o`, `busy_o`, `done_o` and `error_o` are all low.
- R2: The first write goes to register select 0 (control). Its data is the captured control value with bit 0 (power-down) set, bits 1 to 4 (bypass, direct-in, direct-out, clock-enable) cleared, and bits 31:5 unchanged.
- R3: The second write goes to select 1 with the captured multiplier word. The third goes to select 2 with the constant 0x00302062, which sets divide-by-one on both the pre-divider and the post-divider.
- R4: The fourth write goes to select 0 with the first write's value, except that bit 0 is cleared. Bit 4 stays cleared.
- R5: After the fourth write, each lock check samples `lock_i` only once the wait interval has run in full, so the first check comes no earlier than WAIT_CYC cycles later. Lock that rises within 501+501k cycles of the power-up handshake is seen at check k, for k = 0..3 at the default settings.
- R6: If `lock_i` is high at any of the LOCK_TRIES checks, a fifth write goes to select 0 with the fourth write's value plus bit 4 set. `done_o` then rises.
- R7: If no check sees lock, `error_o` rises after exactly four writes, and no write carries bit 4 set.
- R8: A start pulse while `busy_o` is high is ignored. The writes of the running sequence keep their original data.
- R9: `done_o` and `error_o` are never high together. Each holds until the next accepted start, which clears both.
- R10: While `wr_valid_o` is high and `wr_ready_i` is low, the valid, select and data outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| ctrl_cur_i | input | 32 | Present PLL control register value, captured at start |
| mult_i | input | 32 | New multiplier word, captured at start |
| wr_valid_o | output | 1 | Register write request |
| wr_ready_i | input | 1 | PLL side accepts the write |
| wr_sel_o | output | 2 | Register select: 0 control, 1 multiplier, 2 pre/post divider |
| wr_data_o | output | 32 | Write data |
| lock_i | input | 1 | PLL lock flag (status bit 0) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed with lock |
| error_o | output | 1 | Sequence ended without lock |

## Verification
A table of runs varies four things: the control value being preserved, the multiplier word, the write-accept pacing, and the cycle at which lock rises after power-up. The lock times sit on both sides of a check boundary, at the last check and one cycle past it. That separates an off-by-one in the wait counter or the try counter from a correct design. Lock that is present from the start must still not complete the run before the wait elapses, which separates sampling after the interval from sampling at once. Directed tests cover the reset state, a start pulse mid-sequence, and flags held until the next start.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DOWN  = 3'd1,
    ST_MULT  = 3'd2,
    ST_PNDIV = 3'd3,
    ST_UP    = 3'd4,
    ST_WAIT  = 3'd5,
    ST_CHECK = 3'd6,
    ST_ON    = 3'd7
  } seq_state_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_MULT  = 2'd1;
  localparam logic [1:0] SEL_PNDIV = 2'd2;

  localparam int BIT_PWRDN  = 0;
  localparam int BIT_BYPASS = 1;
  localparam int BIT_DIRIN  = 2;
  localparam int BIT_DIROUT = 3;
  localparam int BIT_CLKEN  = 4;

  // Power the loop down; strip bypass, direct paths and output enable.
  function automatic logic [31:0] ctrl_down(input logic [31:0] base);
    logic [31:0] w;
    w = base;
    w[BIT_PWRDN]  = 1'b1;
    w[BIT_BYPASS] = 1'b0;
    w[BIT_DIRIN]  = 1'b0;
    w[BIT_DIROUT] = 1'b0;
    w[BIT_CLKEN]  = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_up(input logic [31:0] base);
    logic [31:0] w;
    w = ctrl_down(base);
    w[BIT_PWRDN] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_on(input logic [31:0] base);
    logic [31:0] w;
    w = ctrl_up(base);
    w[BIT_CLKEN] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || hit_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= LAST)); // R5

endmodule

// File: rtl/pll_seq_tries.sv
module pll_seq_tries #(
  parameter int TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;
  localparam logic [TW-1:0] FINAL = TW'(TRIES - 1);

  logic [TW-1:0] tries_q;

  assign last_o = (tries_q == FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) tries_q <= '0;
    else if (inc_i)      tries_q <= tries_q + 1'b1;
  end

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !last_o); // R7

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          WAIT_NS    = 10_000,
  parameter int          LOCK_TRIES = 4,
  parameter logic [31:0] PNDIV_WORD = 32'h0030_2062
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] ctrl_cur_i,
  input  logic [31:0] mult_i,
  output logic        wr_valid_o,
  input  logic        wr_ready_i,
  output logic [1:0]  wr_sel_o,
  output logic [31:0] wr_data_o,
  input  logic        lock_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        error_o
);
  localparam int WAIT_CYC_RAW = (CLK_HZ / 1000) * (WAIT_NS / 1000) / 1000;
  localparam int WAIT_CYC     = (WAIT_CYC_RAW < 1) ? 1 : WAIT_CYC_RAW;

  seq_state_t  state_q, state_d;
  logic [31:0] base_q, mult_q;
  logic        done_q, err_q;

  // Named events
  logic accept_start, wr_fire, wait_hit, chk_evt, lock_seen, lock_miss;
  logic last_try, fail_evt, pass_evt;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign wr_fire      = wr_valid_o && wr_ready_i;
  assign chk_evt      = (state_q == ST_CHECK);
  assign lock_seen    = chk_evt && lock_i;
  assign lock_miss    = chk_evt && !lock_i;
  assign fail_evt     = lock_miss && last_try;
  assign pass_evt     = (state_q == ST_ON) && wr_ready_i;

  pll_seq_timer #(.LIMIT(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == ST_WAIT),
    .hit_o (wait_hit)
  );

  pll_seq_tries #(.TRIES(LOCK_TRIES)) u_tries (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept_start),
    .inc_i  (lock_miss && !last_try),
    .last_o (last_try)
  );

  always_comb begin
    wr_valid_o = 1'b0;
    wr_sel_o   = SEL_CTRL;
    wr_data_o  = '0;
    unique case (state_q)
      ST_DOWN:  begin wr_valid_o = 1'b1; wr_data_o = ctrl_down(base_q); end
      ST_MULT:  begin wr_valid_o = 1'b1; wr_sel_o = SEL_MULT;  wr_data_o = mult_q; end
      ST_PNDIV: begin wr_valid_o = 1'b1; wr_sel_o = SEL_PNDIV; wr_data_o = PNDIV_WORD; end
      ST_UP:    begin wr_valid_o = 1'b1; wr_data_o = ctrl_up(base_q); end
      ST_ON:    begin wr_valid_o = 1'b1; wr_data_o = ctrl_on(base_q); end
      default:  ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_DOWN;
      ST_DOWN:  if (wr_ready_i) state_d = ST_MULT;
      ST_MULT:  if (wr_ready_i) state_d = ST_PNDIV;
      ST_PNDIV: if (wr_ready_i) state_d = ST_UP;
      ST_UP:    if (wr_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (wait_hit)   state_d = ST_CHECK;
      ST_CHECK: begin
        if (lock_i)        state_d = ST_ON;
        else if (last_try) state_d = ST_IDLE;
        else               state_d = ST_WAIT;
      end
      ST_ON:    if (wr_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      mult_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_start) begin
        base_q <= ctrl_cur_i;
        mult_q <= mult_i;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (pass_evt) done_q <= 1'b1;
      if (fail_evt) err_q  <= 1'b1;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_sel_o) && $stable(wr_data_o))); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o)); // R9
  AST_LOCK_TO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen |=> (wr_valid_o && wr_sel_o == SEL_CTRL && wr_data_o[BIT_CLKEN])); // R6
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !wr_valid_o); // R7
  AST_CHECK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_evt |-> $past(wait_hit)); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(base_q) && $stable(mult_q)); // R8

endmodule

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_cur_i = '0;
  logic [31:0] mult_i = '0;
  logic        wr_valid_o, wr_ready_i, lock_i;
  logic [1:0]  wr_sel_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, error_o;

  always #10 clk = ~clk;

  pll_reprog_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_cur_i(ctrl_cur_i),
    .mult_i(mult_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o), .lock_i(lock_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  int n_checks = 0, n_fail = 0;
  int ncyc = 0;
  int gap = 0;
  int lock_delay = 0;
  int lcnt = 0;
  bit lock_arm = 1'b0;
  int n_log = 0;
  logic [1:0]  log_sel [8];
  logic [31:0] log_dat [8];

  initial begin
    wr_ready_i = 1'b0;
    lock_i = 1'b0;
  end

  // Write-port responder and log, plus lock model; all on the falling edge.
  always @(negedge clk) begin
    ncyc++;
    wr_ready_i = ((ncyc % (gap + 1)) == 0);
    if (lock_arm) lcnt++;
    lock_i = lock_arm && (lcnt >= lock_delay);
    if (wr_valid_o && wr_ready_i && n_log < 8) begin
      log_sel[n_log] = wr_sel_o;
      log_dat[n_log] = wr_data_o;
      n_log++;
      if (n_log == 4) begin lock_arm = 1'b1; lcnt = 0; end
    end
    if (ncyc > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", ncyc);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_down(input logic [31:0] b);
    return {b[31:5], 4'b0000, 1'b1};
  endfunction

  task automatic launch(input logic [31:0] b, input logic [31:0] m);
    n_log = 0; lock_arm = 1'b0; lcnt = 0;
    @(negedge clk);
    ctrl_cur_i = b; mult_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(output int el);
    el = 1;
    while (!(done_o || error_o) && el < 5000) begin
      @(negedge clk); el++;
    end
  endtask

  localparam int NV = 6;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5FE,
                                         32'h1234_561F, 32'h0000_0020, 32'hDEAD_BEE1};
  localparam logic [31:0] V_MULT [NV] = '{32'h0001_8003, 32'h0000_4000, 32'h00AB_CDEF,
                                         32'h0123_4567, 32'h7FFF_FFFF, 32'h0000_0001};
  localparam int V_DELAY [NV] = '{0, 1002, 1003, 2004, 2005, 60000};
  localparam int V_GAP   [NV] = '{0, 1, 2, 0, 3, 0};
  localparam bit V_OK    [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  initial begin
    int el;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'b0, wr_valid_o}, 32'd0);
    check("R1 flags", {29'b0, busy_o, done_o, error_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {30'b0, busy_o, wr_valid_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      gap = V_GAP[v];
      lock_delay = V_DELAY[v];
      launch(V_BASE[v], V_MULT[v]);
      wait_end(el);
      check("R9 exactly one flag", {30'b0, done_o, error_o}, V_OK[v] ? 32'd2 : 32'd1);
      check("R2 first write sel", {30'b0, log_sel[0]}, 32'd0);
      check("R2 first write data", log_dat[0], exp_down(V_BASE[v]));
      check("R3 multiplier write", {log_sel[1], log_dat[1][29:0]}, {2'd1, V_MULT[v][29:0]});
      check("R3 pre/post write", {log_sel[2], log_dat[2][29:0]}, {2'd2, 30'h0030_2062});
      check("R4 power-up write", {log_sel[3], log_dat[3][29:0]},
            {2'd0, exp_down(V_BASE[v])[29:1], 1'b0});
      if (V_OK[v]) begin
        check("R6 write count", n_log, 5);
        check("R6 enable write", log_dat[4], {V_BASE[v][31:5], 5'b10000});
      end else begin
        check("R7 write count", n_log, 4);
        check("R7 enable never set", {31'b0, log_dat[3][4] | log_dat[0][4]}, 32'd0);
      end
      if (v == 0) begin
        // R5: lock already present must still wait the interval
        n_checks++;
        if (el < 500 || el > 520) begin
          n_fail++;
          $display("FAIL R5 first check time: actual=%0d expected=500..520", el);
        end
      end
      lock_arm = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R9: flags hold while idle, next start clears them
    repeat (30) @(negedge clk);
    check("R9 error held", {31'b0, error_o}, 32'd1);
    gap = 2; lock_delay = 0;
    launch(32'h0000_00E0, 32'h0000_0055);
    check("R9 cleared by start", {30'b0, done_o, error_o}, 32'd0);
    check("R8 busy", {31'b0, busy_o}, 32'd1);
    // R8: start mid-sequence is ignored
    @(negedge clk);
    ctrl_cur_i = 32'hFFFF_FFFF; mult_i = 32'h0BAD_0BAD; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end(el);
    check("R8 multiplier kept", log_dat[1], 32'h0000_0055);
    check("R8 control kept", log_dat[0], 32'h0000_00E1);
    check("R8 done", {31'b0, done_o}, 32'd1);
    repeat (25) @(negedge clk);
    check("R9 done held", {30'b0, done_o, busy_o}, 32'd2);

    // R10: valid and data stay while ready is low
    gap = 1000; n_log = 0; lock_arm = 1'b0;
    launch(32'h0000_0000, 32'h0000_0011);
    repeat (3) @(negedge clk);
    check("R10 valid held", {31'b0, wr_valid_o}, 32'd1);
    check("R10 data held", wr_data_o, 32'h0000_0001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {29'b0, wr_valid_o, busy_o, done_o}, 32'd0);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule